// File: doc/BRIEF.md
# Debug Address Comparator Bank

This block holds a set of hardware debug comparators for a processor core. Two kinds of slot exist. Instruction breakpoint slots watch the fetch address stream. Data watchpoint slots watch load and store addresses. Every slot has two registers: an address value and a control word. Software programs both through one indexed register port that has a combinational read path.

A slot matches when four conditions hold:
- the access address, with its low bits dropped, equals the stored value;
- the byte-select mask in the control word has a 1 for the byte the access points at;
- the privilege of the access is one the slot permits;
- for a watchpoint only, the access direction (load or store) is one the slot permits.

A breakpoint slot can also run in inverted mode. In that mode it fires on every enabled fetch that does not match, which lets software step past a trigger. Match results are registered. They appear as a per-slot hit vector, a one-cycle debug event and a cause code, with breakpoint hits taking priority over watchpoint hits. A constant identity word reports how many slots of each kind are built in.

Top module: `dbg_cmp_bank`

## Requirements
- R1: After reset, every value and control register reads as zero, and all hit, event and cause outputs are zero.
- R2: The register index `reg_idx` selects a register kind in bits 5:4 and a slot number in bits 3:0. The kinds are 0 = breakpoint value, 1 = breakpoint control, 2 = watchpoint value and 3 = watchpoint control. A write with `reg_we` high takes effect at the clock edge. `reg_rdata` shows the indexed register in the same cycle. Value registers keep bits 31:2, and bits 1:0 read as zero. A slot number at or above the number of slots built for that kind reads as zero, and writing it changes nothing.
- R3: `cfg_id` carries (watchpoint count - 1) in bits 31:28 and (breakpoint count - 1) in bits 27:24. All its other bits are zero.
- R4: Breakpoint control bits are: bit 0 enable, bit 1 user allowed, bit 2 privileged allowed, bits 8:5 byte select, bit 13 inverted match. All other bits read as zero. A fetch matches when fetch_addr[31:2] equals value[31:2] and select bit fetch_addr[1:0] is 1. The hit appears on `bkpt_hit` in the cycle after the fetch strobe.
- R5: A slot whose enable bit is 0 never produces a hit.
- R6: An access with priv = 1 can match only when the slot's privileged bit is set. An access with priv = 0 can match only when the slot's user bit is set.
- R7: With the inverted-match bit set, an enabled and permitted fetch produces a hit exactly when the address/byte comparison of R4 fails.
- R8: Watchpoint control bits are: bit 0 enable, bit 1 user, bit 2 privileged, bit 3 load, bit 4 store, bits 12:5 byte select. A store (`data_write` = 1) needs the store bit, and a load needs the load bit. Both bits may be set together.
- R9: In 4-byte mode, a watchpoint compares data_addr[31:2] and tests select bit data_addr[1:0]. A single byte or a halfword placed at an offset matches only the bytes it selects.
- R10: When the 8-byte option is built in, a select mask with any of bits 7:4 set puts the watchpoint in 8-byte mode. In that mode it compares data_addr[31:3] and tests select bit data_addr[2:0]. Without the option, select bits 7:4 of a watchpoint control are not stored and read back as zero.
- R11: `dbg_event` is high in the cycle after any slot hits. `evt_cause` is then 1 if any breakpoint hit and 2 if only watchpoints hit. In all other cycles `evt_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 6 | Register kind (5:4) and slot number (3:0) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Indexed register contents |
| cfg_id | output | 32 | Slot count identity word |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | ADDR_W | Fetch address |
| fetch_priv | input | 1 | Fetch is privileged |
| data_valid | input | 1 | Data access strobe |
| data_addr | input | ADDR_W | Data address |
| data_write | input | 1 | Data access is a store |
| data_priv | input | 1 | Data access is privileged |
| bkpt_hit | output | NUM_BKPT | Registered breakpoint hit per slot |
| watch_hit | output | NUM_WATCH | Registered watchpoint hit per slot |
| dbg_event | output | 1 | Debug event pulse |
| evt_cause | output | 2 | 0 none, 1 breakpoint, 2 watchpoint |

## Verification
The main instance is built with four breakpoint slots, two watchpoint slots, a 32-bit address and the 8-byte option enabled. This makes it possible to test inverted matching, privilege gating, direction filtering and double-word lanes side by side, and to hit breakpoints and watchpoints in the same cycle so the cause priority is exercised. A second, smaller instance built without the 8-byte option checks that the upper select bits are dropped and that the identity word changes with the slot counts. Writing to slot numbers above the built counts shows that such writes are ignored.

// File: rtl/dbg_cmp_pkg.sv
package dbg_cmp_pkg;

  localparam int unsigned DATA_W     = 32;
  localparam int unsigned REG_IDX_W  = 6;
  localparam int unsigned SLOT_IDX_W = 4;
  localparam int unsigned SEL_W      = 8;

  typedef enum logic [1:0] {
    RK_BVAL = 2'd0,
    RK_BCTL = 2'd1,
    RK_WVAL = 2'd2,
    RK_WCTL = 2'd3
  } reg_kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_BKPT  = 2'd1,
    CAUSE_WATCH = 2'd2
  } evt_cause_e;

  typedef struct packed {
    logic       mism;
    logic [3:0] sel;
    logic       prv;
    logic       usr;
    logic       en;
  } bkpt_ctl_t;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             st;
    logic             ld;
    logic             prv;
    logic             usr;
    logic             en;
  } watch_ctl_t;

  function automatic bkpt_ctl_t bkpt_ctl_unpack(input logic [DATA_W-1:0] w);
    bkpt_ctl_t c;
    c.en   = w[0];
    c.usr  = w[1];
    c.prv  = w[2];
    c.sel  = w[8:5];
    c.mism = w[13];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] bkpt_ctl_pack(input bkpt_ctl_t c);
    logic [DATA_W-1:0] w;
    w      = '0;
    w[0]   = c.en;
    w[1]   = c.usr;
    w[2]   = c.prv;
    w[8:5] = c.sel;
    w[13]  = c.mism;
    return w;
  endfunction

  function automatic watch_ctl_t watch_ctl_unpack(input logic [DATA_W-1:0] w);
    watch_ctl_t c;
    c.en  = w[0];
    c.usr = w[1];
    c.prv = w[2];
    c.ld  = w[3];
    c.st  = w[4];
    c.sel = w[12:5];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] watch_ctl_pack(input watch_ctl_t c);
    logic [DATA_W-1:0] w;
    w       = '0;
    w[0]    = c.en;
    w[1]    = c.usr;
    w[2]    = c.prv;
    w[3]    = c.ld;
    w[4]    = c.st;
    w[12:5] = c.sel;
    return w;
  endfunction

  function automatic logic priv_allowed(input logic usr_ok, input logic prv_ok,
                                        input logic acc_priv);
    return acc_priv ? prv_ok : usr_ok;
  endfunction

endpackage

// File: rtl/dbg_cfg_regs.sv
module dbg_cfg_regs
  import dbg_cmp_pkg::*;
#(
  parameter int NUM_BKPT        = 4,
  parameter int NUM_WATCH       = 2,
  parameter int ADDR_W          = 32,
  parameter bit HAS_DWORD_WATCH = 1'b1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              reg_we,
  input  logic [REG_IDX_W-1:0]              reg_idx,
  input  logic [DATA_W-1:0]                 reg_wdata,
  output logic [DATA_W-1:0]                 reg_rdata,
  output logic [NUM_BKPT-1:0][ADDR_W-3:0]   bval,
  output bkpt_ctl_t [NUM_BKPT-1:0]          bctl,
  output logic [NUM_WATCH-1:0][ADDR_W-3:0]  wval,
  output watch_ctl_t [NUM_WATCH-1:0]        wctl
);

  localparam int VAL_W = ADDR_W - 2;

  reg_kind_e               kind;
  logic [SLOT_IDX_W-1:0]   slot;

  logic [NUM_BKPT-1:0][VAL_W-1:0]  bval_q, bval_d;
  bkpt_ctl_t [NUM_BKPT-1:0]        bctl_q, bctl_d;
  logic [NUM_WATCH-1:0][VAL_W-1:0] wval_q, wval_d;
  watch_ctl_t [NUM_WATCH-1:0]      wctl_q, wctl_d;

  bkpt_ctl_t  bctl_wr;
  watch_ctl_t wctl_wr;

  assign kind = reg_kind_e'(reg_idx[5:4]);
  assign slot = reg_idx[SLOT_IDX_W-1:0];

  assign bctl_wr = bkpt_ctl_unpack(reg_wdata);

  always_comb begin
    wctl_wr = watch_ctl_unpack(reg_wdata);
    if (!HAS_DWORD_WATCH) begin
      wctl_wr.sel[SEL_W-1:4] = '0;
    end
  end

  // next-state
  always_comb begin
    bval_d = bval_q;
    bctl_d = bctl_q;
    wval_d = wval_q;
    wctl_d = wctl_q;
    if (reg_we) begin
      for (int i = 0; i < NUM_BKPT; i++) begin
        if (slot == SLOT_IDX_W'(i)) begin
          if (kind == RK_BVAL) bval_d[i] = reg_wdata[ADDR_W-1:2];
          if (kind == RK_BCTL) bctl_d[i] = bctl_wr;
        end
      end
      for (int j = 0; j < NUM_WATCH; j++) begin
        if (slot == SLOT_IDX_W'(j)) begin
          if (kind == RK_WVAL) wval_d[j] = reg_wdata[ADDR_W-1:2];
          if (kind == RK_WCTL) wctl_d[j] = wctl_wr;
        end
      end
    end
  end

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bval_q <= '0;
      bctl_q <= '0;
      wval_q <= '0;
      wctl_q <= '0;
    end else if (reg_we) begin
      bval_q <= bval_d;
      bctl_q <= bctl_d;
      wval_q <= wval_d;
      wctl_q <= wctl_d;
    end
  end

  // read path
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_BKPT; i++) begin
      if (slot == SLOT_IDX_W'(i)) begin
        if (kind == RK_BVAL) reg_rdata[ADDR_W-1:2] = bval_q[i];
        if (kind == RK_BCTL) reg_rdata = bkpt_ctl_pack(bctl_q[i]);
      end
    end
    for (int j = 0; j < NUM_WATCH; j++) begin
      if (slot == SLOT_IDX_W'(j)) begin
        if (kind == RK_WVAL) reg_rdata[ADDR_W-1:2] = wval_q[j];
        if (kind == RK_WCTL) reg_rdata = watch_ctl_pack(wctl_q[j]);
      end
    end
  end

  assign bval = bval_q;
  assign bctl = bctl_q;
  assign wval = wval_q;
  assign wctl = wctl_q;

  // a write aimed past the built breakpoint slots leaves the bank untouched
  assert_unimpl_bkpt_write_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (kind == RK_BVAL || kind == RK_BCTL) && int'(slot) >= NUM_BKPT)
      |=> ($stable(bval_q) && $stable(bctl_q)));

  assert_unimpl_watch_write_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (kind == RK_WVAL || kind == RK_WCTL) && int'(slot) >= NUM_WATCH)
      |=> ($stable(wval_q) && $stable(wctl_q)));

endmodule

// File: rtl/dbg_bkpt_slot.sv
module dbg_bkpt_slot
  import dbg_cmp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-3:0] val,
  input  bkpt_ctl_t         ctl,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_priv,
  output logic              hit
);

  logic addr_eq;
  logic lane_on;
  logic raw_match;
  logic gate_ok;

  assign addr_eq   = (val == acc_addr[ADDR_W-1:2]);
  assign lane_on   = ctl.sel[acc_addr[1:0]];
  assign raw_match = addr_eq & lane_on;
  assign gate_ok   = acc_valid & ctl.en & priv_allowed(ctl.usr, ctl.prv, acc_priv);
  assign hit       = gate_ok & (ctl.mism ? ~raw_match : raw_match);

endmodule

// File: rtl/dbg_watch_slot.sv
module dbg_watch_slot
  import dbg_cmp_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter bit HAS_DWORD_WATCH = 1'b1
) (
  input  logic [ADDR_W-3:0] val,
  input  watch_ctl_t        ctl,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_priv,
  output logic              hit
);

  logic addr_eq;
  logic lane_on;
  logic dir_ok;

  generate
    if (HAS_DWORD_WATCH) begin : g_dword
      logic dw_mode;
      logic hi_eq;
      assign dw_mode = |ctl.sel[SEL_W-1:4];
      assign hi_eq   = (val[ADDR_W-3:1] == acc_addr[ADDR_W-1:3]);
      assign addr_eq = dw_mode ? hi_eq : (hi_eq & (val[0] == acc_addr[2]));
      assign lane_on = dw_mode ? ctl.sel[acc_addr[2:0]]
                               : ctl.sel[{1'b0, acc_addr[1:0]}];
    end else begin : g_word
      assign addr_eq = (val == acc_addr[ADDR_W-1:2]);
      assign lane_on = ctl.sel[{1'b0, acc_addr[1:0]}];
    end
  endgenerate

  assign dir_ok = acc_write ? ctl.st : ctl.ld;
  assign hit    = acc_valid & ctl.en & priv_allowed(ctl.usr, ctl.prv, acc_priv)
                & dir_ok & addr_eq & lane_on;

endmodule

// File: rtl/dbg_cmp_bank.sv
module dbg_cmp_bank
  import dbg_cmp_pkg::*;
#(
  parameter int NUM_BKPT        = 4,
  parameter int NUM_WATCH       = 2,
  parameter int ADDR_W          = 32,
  parameter bit HAS_DWORD_WATCH = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [5:0]            reg_idx,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic [31:0]           cfg_id,
  input  logic                  fetch_valid,
  input  logic [ADDR_W-1:0]     fetch_addr,
  input  logic                  fetch_priv,
  input  logic                  data_valid,
  input  logic [ADDR_W-1:0]     data_addr,
  input  logic                  data_write,
  input  logic                  data_priv,
  output logic [NUM_BKPT-1:0]   bkpt_hit,
  output logic [NUM_WATCH-1:0]  watch_hit,
  output logic                  dbg_event,
  output logic [1:0]            evt_cause
);

  localparam int VAL_W = ADDR_W - 2;

  logic [NUM_BKPT-1:0][VAL_W-1:0]  bval;
  bkpt_ctl_t [NUM_BKPT-1:0]        bctl;
  logic [NUM_WATCH-1:0][VAL_W-1:0] wval;
  watch_ctl_t [NUM_WATCH-1:0]      wctl;

  logic [NUM_BKPT-1:0]  bhit_d, bhit_q;
  logic [NUM_WATCH-1:0] whit_d, whit_q;
  logic                 evt_d, evt_q;
  evt_cause_e           cause_d, cause_q;

  assign cfg_id = {4'(NUM_WATCH - 1), 4'(NUM_BKPT - 1), 24'd0};

  dbg_cfg_regs #(
    .NUM_BKPT        (NUM_BKPT),
    .NUM_WATCH       (NUM_WATCH),
    .ADDR_W          (ADDR_W),
    .HAS_DWORD_WATCH (HAS_DWORD_WATCH)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .bval      (bval),
    .bctl      (bctl),
    .wval      (wval),
    .wctl      (wctl)
  );

  generate
    for (genvar b = 0; b < NUM_BKPT; b++) begin : g_bkpt
      dbg_bkpt_slot #(.ADDR_W(ADDR_W)) slot_i (
        .val       (bval[b]),
        .ctl       (bctl[b]),
        .acc_valid (fetch_valid),
        .acc_addr  (fetch_addr),
        .acc_priv  (fetch_priv),
        .hit       (bhit_d[b])
      );

      assert_off_bkpt_silent_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        !bctl[b].en |=> !bkpt_hit[b]);
    end

    for (genvar w = 0; w < NUM_WATCH; w++) begin : g_watch
      dbg_watch_slot #(
        .ADDR_W          (ADDR_W),
        .HAS_DWORD_WATCH (HAS_DWORD_WATCH)
      ) slot_i (
        .val       (wval[w]),
        .ctl       (wctl[w]),
        .acc_valid (data_valid),
        .acc_addr  (data_addr),
        .acc_write (data_write),
        .acc_priv  (data_priv),
        .hit       (whit_d[w])
      );

      assert_off_watch_silent_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        !wctl[w].en |=> !watch_hit[w]);
    end
  endgenerate

  // next-state for the result stage
  always_comb begin
    evt_d = (|bhit_d) | (|whit_d);
    if (|bhit_d) begin
      cause_d = CAUSE_BKPT;
    end else if (|whit_d) begin
      cause_d = CAUSE_WATCH;
    end else begin
      cause_d = CAUSE_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bhit_q  <= '0;
      whit_q  <= '0;
      evt_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      bhit_q  <= bhit_d;
      whit_q  <= whit_d;
      evt_q   <= evt_d;
      cause_q <= cause_d;
    end
  end

  assign bkpt_hit  = bhit_q;
  assign watch_hit = whit_q;
  assign dbg_event = evt_q;
  assign evt_cause = cause_q;

  assert_bkpt_after_fetch_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (|bhit_d) |=> $past(fetch_valid) && (|bkpt_hit));

  assert_watch_after_access_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (|whit_d) |=> $past(data_valid) && (|watch_hit));

  assert_bkpt_wins_cause_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    (|bkpt_hit) |-> (evt_cause == CAUSE_BKPT) && dbg_event);

  assert_quiet_no_cause_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    ((bkpt_hit == '0) && (watch_hit == '0)) |-> (evt_cause == CAUSE_NONE) && !dbg_event);

endmodule

// File: tb/dbg_cmp_bank_tb_top.sv
module dbg_cmp_bank_tb_top;

  localparam int NB = 4;
  localparam int NW = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, cfg_id;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        fetch_priv = 1'b0;
  logic        data_valid = 1'b0;
  logic [31:0] data_addr = '0;
  logic        data_write = 1'b0;
  logic        data_priv = 1'b0;
  logic [NB-1:0] bkpt_hit;
  logic [NW-1:0] watch_hit;
  logic        dbg_event;
  logic [1:0]  evt_cause;

  // instance without the 8-byte option
  logic        n_we = 1'b0;
  logic [5:0]  n_idx = '0;
  logic [31:0] n_wdata = '0;
  logic [31:0] n_rdata, n_id;
  logic [1:0]  n_bhit;
  logic [0:0]  n_whit;
  logic        n_evt;
  logic [1:0]  n_cause;

  always #4 clk = ~clk;

  dbg_cmp_bank #(.NUM_BKPT(NB), .NUM_WATCH(NW), .ADDR_W(32), .HAS_DWORD_WATCH(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cfg_id(cfg_id),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_priv(fetch_priv),
    .data_valid(data_valid), .data_addr(data_addr), .data_write(data_write), .data_priv(data_priv),
    .bkpt_hit(bkpt_hit), .watch_hit(watch_hit), .dbg_event(dbg_event), .evt_cause(evt_cause)
  );

  dbg_cmp_bank #(.NUM_BKPT(2), .NUM_WATCH(1), .ADDR_W(32), .HAS_DWORD_WATCH(1'b0)) dut_nodw_i (
    .clk(clk), .rst_n(rst_n), .reg_we(n_we), .reg_idx(n_idx), .reg_wdata(n_wdata),
    .reg_rdata(n_rdata), .cfg_id(n_id),
    .fetch_valid(1'b0), .fetch_addr(32'd0), .fetch_priv(1'b0),
    .data_valid(1'b0), .data_addr(32'd0), .data_write(1'b0), .data_priv(1'b0),
    .bkpt_hit(n_bhit), .watch_hit(n_whit), .dbg_event(n_evt), .evt_cause(n_cause)
  );

  int    tests = 0;
  int    fails = 0;
  bit    done  = 1'b0;
  string phase = "R1";

  // ---------------- reference model ----------------
  logic [31:0]   m_bval [NB];
  logic [31:0]   m_bctl [NB];
  logic [31:0]   m_wval [NW];
  logic [31:0]   m_wctl [NW];
  logic [NB-1:0] e_bhit;
  logic [NW-1:0] e_whit;
  logic          e_evt;
  logic [1:0]    e_cause;

  function automatic logic m_bkpt(int i);
    logic raw, pok;
    raw = (m_bval[i][31:2] == fetch_addr[31:2]) && m_bctl[i][5 + int'(fetch_addr[1:0])];
    pok = fetch_priv ? m_bctl[i][2] : m_bctl[i][1];
    return fetch_valid && m_bctl[i][0] && pok && (m_bctl[i][13] ? !raw : raw);
  endfunction

  function automatic logic m_watch(int i);
    logic raw, pok, dir;
    if (m_wctl[i][12:9] != 0)
      raw = (m_wval[i][31:3] == data_addr[31:3]) && m_wctl[i][5 + int'(data_addr[2:0])];
    else
      raw = (m_wval[i][31:2] == data_addr[31:2]) && m_wctl[i][5 + int'(data_addr[1:0])];
    pok = data_priv ? m_wctl[i][2] : m_wctl[i][1];
    dir = data_write ? m_wctl[i][4] : m_wctl[i][3];
    return data_valid && m_wctl[i][0] && pok && dir && raw;
  endfunction

  function automatic logic [31:0] m_read(logic [5:0] idx);
    int s;
    s = int'(idx[3:0]);
    case (idx[5:4])
      2'd0: return (s < NB) ? m_bval[s] : 32'd0;
      2'd1: return (s < NB) ? m_bctl[s] : 32'd0;
      2'd2: return (s < NW) ? m_wval[s] : 32'd0;
      default: return (s < NW) ? m_wctl[s] : 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin m_bval[i] <= '0; m_bctl[i] <= '0; end
      for (int i = 0; i < NW; i++) begin m_wval[i] <= '0; m_wctl[i] <= '0; end
      e_bhit <= '0; e_whit <= '0; e_evt <= 1'b0; e_cause <= 2'd0;
    end else begin
      logic [NB-1:0] tb;
      logic [NW-1:0] tw;
      int s;
      for (int i = 0; i < NB; i++) tb[i] = m_bkpt(i);
      for (int i = 0; i < NW; i++) tw[i] = m_watch(i);
      e_bhit  <= tb;
      e_whit  <= tw;
      e_evt   <= (tb != 0) || (tw != 0);
      e_cause <= (tb != 0) ? 2'd1 : ((tw != 0) ? 2'd2 : 2'd0);
      s = int'(reg_idx[3:0]);
      if (reg_we) begin
        case (reg_idx[5:4])
          2'd0: if (s < NB) m_bval[s] <= reg_wdata & 32'hFFFF_FFFC;
          2'd1: if (s < NB) m_bctl[s] <= reg_wdata & 32'h0000_21E7;
          2'd2: if (s < NW) m_wval[s] <= reg_wdata & 32'hFFFF_FFFC;
          default: if (s < NW) m_wctl[s] <= reg_wdata & 32'h0000_1FFF;
        endcase
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk({phase, " hits/event/cause"},
        64'({bkpt_hit, watch_hit, dbg_event, evt_cause}),
        64'({e_bhit, e_whit, e_evt, e_cause}));
    chk({phase, " rdata"}, 64'(reg_rdata), 64'(m_read(reg_idx)));
  endtask

  task automatic tick();
    @(negedge clk);
    cmp_all();
  endtask

  task automatic quiet();
    reg_we = 1'b0; fetch_valid = 1'b0; data_valid = 1'b0;
  endtask

  task automatic wr(logic [5:0] idx, logic [31:0] d);
    quiet(); reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] idx);
    quiet(); reg_idx = idx;
    tick();
  endtask

  task automatic fetch(logic [31:0] a, logic p);
    quiet(); fetch_valid = 1'b1; fetch_addr = a; fetch_priv = p;
    tick();
  endtask

  task automatic dacc(logic [31:0] a, logic w, logic p);
    quiet(); data_valid = 1'b1; data_addr = a; data_write = w; data_priv = p;
    tick();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: everything clear after reset
    phase = "R1";
    for (int k = 0; k < 64; k++) rd(6'(k));
    chk("R1 outputs idle", 64'({bkpt_hit, watch_hit, dbg_event, evt_cause}), 64'd0);

    // R3: identity words
    chk("R3 id main", 64'(cfg_id), 64'h1300_0000);
    chk("R3 id small", 64'(n_id), 64'h0100_0000);

    // R2: readback and unimplemented slots
    phase = "R2";
    wr(6'h00, 32'h0000_1003);
    rd(6'h00);
    chk("R2 value low bits dropped", 64'(reg_rdata), 64'h0000_1000);
    wr(6'h07, 32'hDEAD_BEEF);
    wr(6'h17, 32'hFFFF_FFFF);
    wr(6'h25, 32'h1234_5678);
    wr(6'h33, 32'hFFFF_FFFF);
    rd(6'h07);
    chk("R2 unimplemented reads zero", 64'(reg_rdata), 64'd0);
    for (int k = 0; k < 64; k++) rd(6'(k));

    // R4: breakpoint word match with byte lanes
    phase = "R4";
    wr(6'h10, 32'h0000_01E7);
    fetch(32'h0000_1000, 1'b0);
    chk("R4 hit on word", 64'(bkpt_hit), 64'h1);
    fetch(32'h0000_1002, 1'b1);
    fetch(32'h0000_1004, 1'b0);
    chk("R4 next word misses", 64'(bkpt_hit), 64'h0);
    wr(6'h01, 32'h0000_2000);
    wr(6'h11, 32'h0000_0067);
    fetch(32'h0000_2002, 1'b0);
    fetch(32'h0000_2000, 1'b0);
    fetch(32'h0000_2001, 1'b0);
    quiet(); tick();

    // R6: privilege gating
    phase = "R6";
    wr(6'h10, 32'h0000_01E3);
    fetch(32'h0000_1000, 1'b1);
    chk("R6 privileged blocked", 64'(bkpt_hit), 64'h0);
    fetch(32'h0000_1000, 1'b0);
    wr(6'h10, 32'h0000_01E5);
    fetch(32'h0000_1000, 1'b0);
    fetch(32'h0000_1000, 1'b1);

    // R5: disabled slot silent
    phase = "R5";
    wr(6'h10, 32'h0000_01E6);
    fetch(32'h0000_1000, 1'b0);
    chk("R5 disabled no hit", 64'(bkpt_hit), 64'h0);
    fetch(32'h0000_1000, 1'b1);

    // R7: inverted match
    phase = "R7";
    wr(6'h11, 32'h0);
    wr(6'h02, 32'h0000_3000);
    wr(6'h12, 32'h0000_21E7);
    fetch(32'h0000_3000, 1'b0);
    chk("R7 programmed address quiet", 64'(bkpt_hit), 64'h0);
    fetch(32'h0000_3100, 1'b0);
    chk("R7 other address fires", 64'(bkpt_hit), 64'h4);
    fetch(32'h0000_3002, 1'b1);
    quiet(); tick();
    chk("R7 no fetch no hit", 64'(bkpt_hit), 64'h0);
    wr(6'h12, 32'h0);

    // R8: direction filter
    phase = "R8";
    wr(6'h20, 32'h0000_4000);
    wr(6'h30, 32'h0000_01EF);
    dacc(32'h0000_4000, 1'b0, 1'b0);
    chk("R8 load hits", 64'(watch_hit), 64'h1);
    dacc(32'h0000_4000, 1'b1, 1'b0);
    chk("R8 store filtered", 64'(watch_hit), 64'h0);
    wr(6'h30, 32'h0000_01F7);
    dacc(32'h0000_4000, 1'b1, 1'b1);
    dacc(32'h0000_4001, 1'b0, 1'b1);
    wr(6'h30, 32'h0000_01FF);
    dacc(32'h0000_4003, 1'b1, 1'b0);
    dacc(32'h0000_4002, 1'b0, 1'b0);

    // R9: single byte at offset 2
    phase = "R9";
    wr(6'h21, 32'h0000_5000);
    wr(6'h31, 32'h0000_009F);
    dacc(32'h0000_5002, 1'b0, 1'b0);
    chk("R9 selected byte", 64'(watch_hit), 64'h2);
    dacc(32'h0000_5001, 1'b0, 1'b0);
    chk("R9 unselected byte", 64'(watch_hit), 64'h0);
    dacc(32'h0000_5003, 1'b1, 1'b0);

    // R10: double-word mode and option readback
    phase = "R10";
    wr(6'h20, 32'h0000_6000);
    wr(6'h30, 32'h0000_1FFF);
    rd(6'h30);
    chk("R10 full mask kept", 64'(reg_rdata), 64'h1FFF);
    dacc(32'h0000_6004, 1'b0, 1'b0);
    chk("R10 upper word lane", 64'(watch_hit), 64'h1);
    dacc(32'h0000_6007, 1'b1, 1'b1);
    dacc(32'h0000_6008, 1'b0, 1'b0);
    wr(6'h30, 32'h0000_1E1F);
    dacc(32'h0000_6000, 1'b0, 1'b0);
    dacc(32'h0000_6006, 1'b0, 1'b0);
    @(negedge clk);
    n_we = 1'b1; n_idx = 6'h30; n_wdata = 32'h0000_1FFF;
    @(negedge clk);
    n_we = 1'b0;
    #1;
    chk("R10 no option drops upper lanes", 64'(n_rdata), 64'h01FF);

    // R11: event pulse and cause priority
    phase = "R11";
    wr(6'h10, 32'h0000_01E7);
    quiet();
    fetch_valid = 1'b1; fetch_addr = 32'h0000_1000; fetch_priv = 1'b0;
    data_valid = 1'b1; data_addr = 32'h0000_6006; data_write = 1'b0; data_priv = 1'b0;
    tick();
    chk("R11 breakpoint wins cause", 64'(evt_cause), 64'd1);
    chk("R11 event raised", 64'(dbg_event), 64'd1);
    dacc(32'h0000_6006, 1'b0, 1'b0);
    chk("R11 watch cause", 64'(evt_cause), 64'd2);
    quiet(); tick();
    chk("R11 pulse ends", 64'({dbg_event, evt_cause}), 64'd0);
    tick();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule